// File: doc/BRIEF.md
# Latching Interrupt Source Controller

This block watches a set of interrupt input lines from a peripheral and turns qualifying events into per-channel notification pulses toward a host. Each channel is configured for level or edge sensing and for which polarity counts as active. A channel also has an enable bit, a host-visible sticky status bit, and a write-one-to-clear control.

Behind each status bit sits a private capture flag that the host cannot read. The flag records any qualifying event, whether or not the channel is enabled. While a channel is disabled, the flag is the only thing that changes. When the enable bit is later raised, a captured event is released at once: the status bit sets and a notification pulse goes out. Software that wants disabled-time events forgotten writes the channel's clear bit just before enabling it. Rewriting an enable bit that is already set leaves a pending status bit alone.

The host reaches the block through a small synchronous register port with an address, write data, a write strobe and combinational read data.

Top module: `intsrc_ctrl`

## Requirements
- R1: Synchronous active-low reset puts the mode, polarity, enable and status registers and the private capture flags at zero, and holds every notification output low.
- R2: Offset 0 (mode, 1 = edge, 0 = level), offset 1 (polarity) and offset 2 (enable) read back the value last written. Offset 3 reads the status bits. Offset 4 (clear) and offsets 5 to 7 read as zero. The capture flags are visible at no offset.
- R3: A level-mode channel is active while its input equals its polarity bit (1 = high, 0 = low). An enabled level channel whose input becomes active at a clock edge shows its status bit set, with a notification, in the following cycle.
- R4: An edge-mode channel triggers when its input differs from the value sampled one clock earlier, in the direction given by polarity (1 = rising, 0 = falling). A change in the opposite direction has no effect.
- R5: An event on a disabled channel sets only its capture flag. The status register and the notification output do not change.
- R6: Writing a 1 to an enable bit that was 0 while that channel's capture flag is set sets the status bit in the same clock as the enable write, and a notification pulse is issued.
- R7: Writing 1 to a bit at offset 4 clears that channel's capture flag and status bit. Doing this before enabling suppresses an event captured while the channel was disabled.
- R8: When a clear and an active trigger coincide, the trigger wins. A level-mode channel whose input is still active keeps its status bit set through a clear.
- R9: Writing an enable bit that is already 1 again leaves a pending status bit unchanged and issues no new notification.
- R10: The notification for a channel is high for exactly one clock, in the cycle its status bit goes from 0 to 1, and at no other time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Synchronous reset, active low |
| src_i | input | NCH | Interrupt input lines, one per channel |
| bus_addr_i | input | AW | Register offset |
| bus_wdata_i | input | NCH | Write data, one bit per channel |
| bus_we_i | input | 1 | Write strobe |
| bus_rdata_o | output | NCH | Read data for the offset on bus_addr_i |
| notify_o | output | NCH | One-clock notification pulse per channel |

## Verification
A capture flag that is wrongly set or wrongly cleared cannot be seen directly, because no offset reads it. It shows only when the channel is next enabled: either a notification pulse appears on the enable write that should have been silent, or an expected pulse never comes. The bench therefore captures events on disabled channels and then enables them, both with and without a prior clear, and checks the notification output in the cycle right after each enable write. A status bit with a wrong value shows at offset 3 one cycle after the event, and a missing or doubled notification shows on the same edge that the status bit changes.

// File: rtl/intsrc_pkg.sv
package intsrc_pkg;
    // register offsets; the ordering is fixed by the register map
    localparam int unsigned OFS_MODE   = 0;
    localparam int unsigned OFS_POL    = 1;
    localparam int unsigned OFS_ENABLE = 2;
    localparam int unsigned OFS_STATUS = 3;
    localparam int unsigned OFS_CLEAR  = 4;

    // per-channel mode encoding
    localparam logic MODE_LEVEL = 1'b0;
    localparam logic MODE_EDGE  = 1'b1;
endpackage

// File: rtl/intsrc_detect.sv
// Trigger detection: level or edge, either polarity, one lane per channel.
module intsrc_detect #(
    parameter int unsigned NCH = 8
) (
    input  logic           clk_i,
    input  logic           rst_ni,
    input  logic [NCH-1:0] src_i,
    input  logic [NCH-1:0] mode_i,
    input  logic [NCH-1:0] pol_i,
    output logic [NCH-1:0] trig_o
);
    import intsrc_pkg::*;

    logic [NCH-1:0] prev_d, prev_q;

    always_comb begin
        prev_d = src_i;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) prev_q <= '0;
        else         prev_q <= prev_d;
    end

    for (genvar g = 0; g < NCH; g++) begin : g_lane
        logic lvl_hit, edge_hit;
        // level: input equals the polarity bit
        assign lvl_hit  = (src_i[g] == pol_i[g]);
        // edge: input moved into the polarity value since the last sample
        assign edge_hit = (src_i[g] == pol_i[g]) && (prev_q[g] != pol_i[g]);
        assign trig_o[g] = (mode_i[g] == MODE_EDGE) ? edge_hit : lvl_hit;
    end
endmodule

// File: rtl/intsrc_latch.sv
// Private capture flag, sticky status and notification pulse per channel.
module intsrc_latch #(
    parameter int unsigned NCH = 8
) (
    input  logic           clk_i,
    input  logic           rst_ni,
    input  logic [NCH-1:0] trig_i,
    input  logic [NCH-1:0] clr_i,
    input  logic [NCH-1:0] en_nxt_i,
    output logic [NCH-1:0] status_o,
    output logic [NCH-1:0] notify_o
);
    typedef struct packed {
        logic [NCH-1:0] cap;
        logic [NCH-1:0] sta;
        logic [NCH-1:0] ntf;
    } lat_t;

    lat_t st_d, st_q;

    always_comb begin
        // a trigger in the same cycle as a clear wins
        st_d.cap = (st_q.cap & ~clr_i) | trig_i;
        // status follows the capture flag whenever the next enable is set;
        // this makes a held event visible on the enable write itself
        st_d.sta = (st_q.sta & ~clr_i) | (en_nxt_i & st_d.cap);
        st_d.ntf = st_d.sta & ~st_q.sta;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign status_o = st_q.sta;
    assign notify_o = st_q.ntf;
endmodule

// File: rtl/intsrc_regs.sv
// Host register file: mode, polarity, enable, status readback, clear strobe.
module intsrc_regs #(
    parameter int unsigned NCH = 8,
    parameter int unsigned AW  = 3
) (
    input  logic           clk_i,
    input  logic           rst_ni,
    input  logic [AW-1:0]  addr_i,
    input  logic [NCH-1:0] wdata_i,
    input  logic           we_i,
    input  logic [NCH-1:0] status_i,
    output logic [NCH-1:0] mode_o,
    output logic [NCH-1:0] pol_o,
    output logic [NCH-1:0] en_q_o,
    output logic [NCH-1:0] en_d_o,
    output logic [NCH-1:0] clr_o,
    output logic [NCH-1:0] rdata_o
);
    import intsrc_pkg::*;

    localparam logic [AW-1:0] A_MODE = AW'(OFS_MODE);
    localparam logic [AW-1:0] A_POL  = AW'(OFS_POL);
    localparam logic [AW-1:0] A_EN   = AW'(OFS_ENABLE);
    localparam logic [AW-1:0] A_STA  = AW'(OFS_STATUS);
    localparam logic [AW-1:0] A_CLR  = AW'(OFS_CLEAR);

    typedef struct packed {
        logic [NCH-1:0] mode;
        logic [NCH-1:0] pol;
        logic [NCH-1:0] en;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        clr_o = '0;
        if (we_i) begin
            unique case (addr_i)
                A_MODE:  cfg_d.mode = wdata_i;
                A_POL:   cfg_d.pol  = wdata_i;
                A_EN:    cfg_d.en   = wdata_i;
                A_CLR:   clr_o      = wdata_i;
                default: ;
            endcase
        end
    end

    always_comb begin
        unique case (addr_i)
            A_MODE:  rdata_o = cfg_q.mode;
            A_POL:   rdata_o = cfg_q.pol;
            A_EN:    rdata_o = cfg_q.en;
            A_STA:   rdata_o = status_i;
            default: rdata_o = '0;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) cfg_q <= '0;
        else         cfg_q <= cfg_d;
    end

    assign mode_o = cfg_q.mode;
    assign pol_o  = cfg_q.pol;
    assign en_q_o = cfg_q.en;
    assign en_d_o = cfg_d.en;
endmodule

// File: rtl/intsrc_ctrl.sv
module intsrc_ctrl #(
    parameter int unsigned NCH = 8,
    parameter int unsigned AW  = 3
) (
    input  logic           clk_i,
    input  logic           rst_ni,
    input  logic [NCH-1:0] src_i,
    input  logic [AW-1:0]  bus_addr_i,
    input  logic [NCH-1:0] bus_wdata_i,
    input  logic           bus_we_i,
    output logic [NCH-1:0] bus_rdata_o,
    output logic [NCH-1:0] notify_o
);
    logic [NCH-1:0] mode, pol, en_q, en_d, clr_mask, trig, status;

    intsrc_regs #(.NCH(NCH), .AW(AW)) u_regs (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .addr_i   (bus_addr_i),
        .wdata_i  (bus_wdata_i),
        .we_i     (bus_we_i),
        .status_i (status),
        .mode_o   (mode),
        .pol_o    (pol),
        .en_q_o   (en_q),
        .en_d_o   (en_d),
        .clr_o    (clr_mask),
        .rdata_o  (bus_rdata_o)
    );

    intsrc_detect #(.NCH(NCH)) u_detect (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .src_i  (src_i),
        .mode_i (mode),
        .pol_i  (pol),
        .trig_o (trig)
    );

    intsrc_latch #(.NCH(NCH)) u_latch (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .trig_i   (trig),
        .clr_i    (clr_mask),
        .en_nxt_i (en_d),
        .status_o (status),
        .notify_o (notify_o)
    );
endmodule

// File: rtl/intsrc_ctrl_chk.sv
module intsrc_ctrl_chk #(
    parameter int unsigned NCH = 8,
    parameter int unsigned AW  = 3
) (
    input logic           clk_i,
    input logic           rst_ni,
    input logic [AW-1:0]  addr,
    input logic [NCH-1:0] rdata,
    input logic [NCH-1:0] en_q,
    input logic [NCH-1:0] status,
    input logic [NCH-1:0] notify,
    input logic [NCH-1:0] clr_mask,
    input logic [NCH-1:0] trig
);
    localparam logic [AW-1:0] FIRST_ZERO_OFS = AW'(4);

    // R2: clear offset and unused offsets read as zero
    assert_unmapped_zero_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (addr >= FIRST_ZERO_OFS) |-> (rdata == '0));

    // R5: a status bit never rises on a channel that is disabled afterwards
    assert_disabled_silent_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((status & ~$past(status) & ~en_q) == '0));

    // R5: no notification on a disabled channel
    assert_notify_enabled_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((notify & ~en_q) == '0));

    // R7: a clear without a coinciding trigger leaves the status bit low
    assert_clear_drops_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((status & $past(clr_mask & ~trig)) == '0));

    // R10: notification coincides with a status rise
    assert_notify_on_rise_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (notify == (status & ~$past(status))));

    // R10: never high two cycles running
    assert_notify_single_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((notify & $past(notify)) == '0));
endmodule

bind intsrc_ctrl intsrc_ctrl_chk #(.NCH(NCH), .AW(AW)) u_chk (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .addr     (bus_addr_i),
    .rdata    (bus_rdata_o),
    .en_q     (en_q),
    .status   (status),
    .notify   (notify_o),
    .clr_mask (clr_mask),
    .trig     (trig)
);

// File: tb/tb_intsrc_ctrl.sv
`timescale 1ns/1ps
module tb_intsrc_ctrl;
    localparam int NCH = 8;
    localparam int AW  = 3;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [NCH-1:0] src = '0;
    logic [AW-1:0]  addr = '0;
    logic [NCH-1:0] wdata = '0;
    logic           we = 1'b0;
    logic [NCH-1:0] rdata, notify;

    always #4 clk = ~clk;  // 125 MHz

    intsrc_ctrl #(.NCH(NCH), .AW(AW)) dut (
        .clk_i(clk), .rst_ni(rst_n), .src_i(src),
        .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_we_i(we),
        .bus_rdata_o(rdata), .notify_o(notify)
    );

    typedef struct {
        string          req;
        logic [NCH-1:0] exp;
        bit             is_ntf;
    } item_t;

    item_t q[$];
    int n_vec = 0;
    int n_bad = 0;
    bit done = 1'b0;

    // monitor: compares queued expectations just after each falling edge
    always begin
        @(negedge clk);
        #1;
        while (q.size() > 0) begin
            item_t it;
            logic [NCH-1:0] got;
            it = q.pop_front();
            got = it.is_ntf ? notify : rdata;
            n_vec++;
            if (got !== it.exp) begin
                n_bad++;
                $display("FAIL %s: %s got %h expected %h", it.req,
                         it.is_ntf ? "notify" : "rdata", got, it.exp);
            end
        end
    end

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [NCH-1:0] d);
        @(negedge clk);
        addr = a; wdata = d; we = 1'b1;
        @(negedge clk);
        we = 1'b0;
    endtask

    // register check on the next falling edge
    task automatic chk_reg(input logic [AW-1:0] a, input logic [NCH-1:0] e, input string r);
        item_t it;
        @(negedge clk);
        addr = a;
        it.req = r; it.exp = e; it.is_ntf = 1'b0;
        q.push_back(it);
    endtask

    // notification check on the current falling edge
    task automatic chk_ntf(input logic [NCH-1:0] e, input string r);
        item_t it;
        it.req = r; it.exp = e; it.is_ntf = 1'b1;
        q.push_back(it);
    endtask

    task automatic finish_run();
        #2;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            finish_run();
        end
    end

    initial begin
        // R1: reset state
        repeat (3) tick();
        chk_ntf('0, "R1");
        chk_reg(3'd0, 8'h00, "R1");
        chk_reg(3'd1, 8'h00, "R1");
        chk_reg(3'd2, 8'h00, "R1");
        chk_reg(3'd3, 8'h00, "R1");
        chk_ntf('0, "R1");
        tick();
        rst_n = 1'b1;

        // configure: ch4..7 edge, all active-high; flush captures
        wr(3'd0, 8'hF0);
        wr(3'd1, 8'hFF);
        wr(3'd4, 8'hFF);
        chk_reg(3'd0, 8'hF0, "R2");
        chk_reg(3'd1, 8'hFF, "R2");
        chk_reg(3'd3, 8'h00, "R7");

        // R3: level, active high, enabled
        wr(3'd2, 8'h01);
        chk_ntf(8'h00, "R7");
        chk_reg(3'd2, 8'h01, "R2");
        tick(); src[0] = 1'b1;
        tick();
        chk_ntf(8'h01, "R3");
        chk_reg(3'd3, 8'h01, "R3");
        chk_ntf(8'h00, "R10");

        // R8: clear while level still active
        wr(3'd4, 8'h01);
        chk_ntf(8'h00, "R8");
        chk_reg(3'd3, 8'h01, "R8");
        tick(); src[0] = 1'b0;
        wr(3'd4, 8'h01);
        chk_reg(3'd3, 8'h00, "R7");
        chk_ntf(8'h00, "R10");

        // R5: event on a disabled channel stays hidden
        tick(); src[1] = 1'b1;
        tick(); src[1] = 1'b0;
        chk_ntf(8'h00, "R5");
        chk_reg(3'd3, 8'h00, "R5");
        chk_ntf(8'h00, "R5");

        // R6: enabling releases the held event
        wr(3'd2, 8'h03);
        chk_ntf(8'h02, "R6");
        chk_reg(3'd3, 8'h02, "R6");
        chk_ntf(8'h00, "R10");

        // R9: rewrite of a set enable bit
        wr(3'd2, 8'h03);
        chk_ntf(8'h00, "R9");
        chk_reg(3'd3, 8'h02, "R9");

        // R7: clear before enable suppresses the stale event
        tick(); src[2] = 1'b1;
        tick(); src[2] = 1'b0;
        wr(3'd4, 8'h04);
        wr(3'd2, 8'h07);
        chk_ntf(8'h00, "R7");
        chk_reg(3'd3, 8'h02, "R7");

        // R4: rising edge on ch4
        wr(3'd2, 8'h17);
        chk_ntf(8'h00, "R4");
        tick(); src[4] = 1'b1;
        tick();
        chk_ntf(8'h10, "R4");
        chk_reg(3'd3, 8'h12, "R4");
        wr(3'd4, 8'h10);
        chk_reg(3'd3, 8'h02, "R4");
        tick(); src[4] = 1'b0;
        tick();
        chk_ntf(8'h00, "R4");
        chk_reg(3'd3, 8'h02, "R4");

        // R4: falling edge on ch5
        wr(3'd1, 8'hDF);
        wr(3'd2, 8'h37);
        chk_ntf(8'h00, "R4");
        tick(); src[5] = 1'b1;
        tick();
        chk_ntf(8'h00, "R4");
        chk_reg(3'd3, 8'h02, "R4");
        tick(); src[5] = 1'b0;
        tick();
        chk_ntf(8'h20, "R4");
        chk_reg(3'd3, 8'h22, "R4");

        // R3/R8: active-low level on disabled ch3, clear loses to active level
        wr(3'd1, 8'hD7);
        chk_reg(3'd3, 8'h22, "R5");
        wr(3'd4, 8'h08);
        wr(3'd2, 8'h3F);
        chk_ntf(8'h08, "R8");
        chk_reg(3'd3, 8'h2A, "R3");

        // R2: clear offset and unused offsets read zero
        chk_reg(3'd4, 8'h00, "R2");
        chk_reg(3'd5, 8'h00, "R2");
        chk_reg(3'd6, 8'h00, "R2");
        chk_reg(3'd7, 8'h00, "R2");
        chk_reg(3'd2, 8'h3F, "R2");

        tick();
        tick();
        done = 1'b1;
        finish_run();
    end
endmodule